// File: doc/BRIEF.md
# Local-to-Wishbone Master Bridge

The bridge accepts single-cycle register requests from a local agent and carries each one out as a Wishbone classic bus cycle. A local request is a one-clock pulse on either the write strobe or the read strobe, with the address and the write data valid in that same cycle. The bridge latches the request and raises the bus cycle on the following clock. It holds the cycle until the slave answers with an acknowledge or an error, then reports the outcome to the local side with a single acknowledge pulse.

Only one transaction is in flight at any time. A request in which both strobes are high is rejected and never reaches the bus. Requests that arrive while a cycle is still open are dropped. Address and data widths are parameters.

Top module: `lwb_bridge`

## Requirements
- R1: A synchronous active-high reset drives bus_cyc, bus_stb, bus_we, loc_done and loc_fault low and returns the bridge to idle.
- R2: A request is valid when exactly one of loc_wr and loc_rd is high. When both are high in the same cycle, the request is discarded and bus_cyc stays low.
- R3: After a valid request sampled at clock edge N, bus_cyc and bus_stb are high from edge N+1.
- R4: During a bus cycle, bus_adr equals the address captured with the request, and bus_we is 1 for a write and 0 for a read.
- R5: During a write cycle, bus_dat_o equals the write data captured with the request.
- R6: bus_cyc, bus_stb, bus_we, bus_adr and bus_dat_o stay unchanged while the cycle is open and neither bus_ack nor bus_err is high. They are deasserted on the edge that samples bus_ack or bus_err.
- R7: loc_done pulses high for exactly one cycle, in the cycle after the edge that samples bus_ack or bus_err. For a read that ends with bus_ack, loc_rdata holds the slave's data during that pulse.
- R8: A cycle that ends with bus_err raises loc_fault in the same cycle as loc_done. A cycle that ends with bus_ack leaves loc_fault low.
- R9: Local requests that arrive while a bus cycle is open are ignored. The bridge is idle after the cycle ends and stays idle until a new valid request arrives.
- R10: When bus_ack and bus_err are both high, the cycle ends and is reported as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loc_wr | input | 1 | Local write request strobe |
| loc_rd | input | 1 | Local read request strobe |
| loc_addr | input | AW | Local request address |
| loc_wdata | input | DW | Local write data |
| loc_rdata | output | DW | Read data returned to the local side |
| loc_done | output | 1 | Transaction complete pulse |
| loc_fault | output | 1 | Transaction ended with a bus error |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Bus strobe |
| bus_we | output | 1 | Bus write enable |
| bus_adr | output | AW | Bus address |
| bus_dat_o | output | DW | Bus write data |
| bus_dat_i | input | DW | Bus read data |
| bus_ack | input | 1 | Slave acknowledge |
| bus_err | input | 1 | Slave error |

## Verification
A wrong state would show up on the very next clock as a mismatch on bus_cyc, bus_stb or loc_done. Examples are a busy flag that never clears, a cycle that opens for a double-strobe request, or a cycle that closes without a slave response. A corrupted address or data latch shows up on bus_adr or bus_dat_o in the first cycle of the transfer and in every cycle it is held. A wrong end-of-cycle decode shows up on loc_fault or loc_rdata in the single cycle that loc_done is high. The bench model predicts every output on every clock, so each of these faults is caught within one cycle of the point where it becomes visible.

// File: rtl/lwb_pkg.sv
package lwb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } lwb_state_e;

    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_OK   = 2'd1,
        END_FAIL = 2'd2
    } lwb_end_e;

    // Classifies the slave response; an error wins over an acknowledge.
    function automatic lwb_end_e classify_end(input logic ack, input logic err);
        if (err)      return END_FAIL;
        else if (ack) return END_OK;
        else          return END_NONE;
    endfunction
endpackage

// File: rtl/lwb_req_decode.sv
module lwb_req_decode (
    input  logic wr,
    input  logic rd,
    output logic valid,
    output logic is_write
);
    assign valid    = wr ^ rd;
    assign is_write = wr;
endmodule

// File: rtl/lwb_cycle_fsm.sv
module lwb_cycle_fsm
    import lwb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ack,
    input  logic          err,
    output logic          cyc,
    output logic          we,
    output logic [AW-1:0] adr,
    output logic [DW-1:0] wdat,
    output lwb_end_e      done_kind
);
    typedef struct packed {
        lwb_state_e    state;
        logic          we;
        logic [AW-1:0] adr;
        logic [DW-1:0] wdat;
        lwb_end_e      fin;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    lwb_end_e resp;

    always_comb begin
        resp  = classify_end(ack, err);
        nxt_d = cur_q;
        nxt_d.fin = END_NONE;
        case (cur_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_d.state = ST_BUSY;
                    nxt_d.we    = req_write;
                    nxt_d.adr   = req_addr;
                    nxt_d.wdat  = req_wdata;
                end
            end
            ST_BUSY: begin
                if (resp != END_NONE) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.we    = 1'b0;
                    nxt_d.fin   = resp;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.state <= ST_IDLE;
            cur_q.we    <= 1'b0;
            cur_q.adr   <= '0;
            cur_q.wdat  <= '0;
            cur_q.fin   <= END_NONE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign cyc       = (cur_q.state == ST_BUSY);
    assign we        = cur_q.we;
    assign adr       = cur_q.adr;
    assign wdat      = cur_q.wdat;
    assign done_kind = cur_q.fin;
endmodule

// File: rtl/lwb_resp_stage.sv
module lwb_resp_stage #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] bus_data,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic [DW-1:0] data;
    } rsp_t;

    rsp_t rsp_q, rsp_d;

    always_comb begin
        rsp_d = rsp_q;
        if (capture) rsp_d.data = bus_data;
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_d;
    end

    assign rdata = rsp_q.data;
endmodule

// File: rtl/lwb_bridge.sv
module lwb_bridge
    import lwb_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          loc_wr,
    input  logic          loc_rd,
    input  logic [AW-1:0] loc_addr,
    input  logic [DW-1:0] loc_wdata,
    output logic [DW-1:0] loc_rdata,
    output logic          loc_done,
    output logic          loc_fault,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic          bus_we,
    output logic [AW-1:0] bus_adr,
    output logic [DW-1:0] bus_dat_o,
    input  logic [DW-1:0] bus_dat_i,
    input  logic          bus_ack,
    input  logic          bus_err
);
    logic     req_valid, req_write, cyc_w;
    lwb_end_e kind;

    lwb_req_decode u_dec (
        .wr       (loc_wr),
        .rd       (loc_rd),
        .valid    (req_valid),
        .is_write (req_write)
    );

    lwb_cycle_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (loc_addr),
        .req_wdata (loc_wdata),
        .ack       (bus_ack),
        .err       (bus_err),
        .cyc       (cyc_w),
        .we        (bus_we),
        .adr       (bus_adr),
        .wdat      (bus_dat_o),
        .done_kind (kind)
    );

    // Read data is captured only on the edge that ends an open cycle.
    lwb_resp_stage #(.DW(DW)) u_rsp (
        .clk      (clk),
        .rst      (rst),
        .capture  (cyc_w & (bus_ack | bus_err)),
        .bus_data (bus_dat_i),
        .rdata    (loc_rdata)
    );

    assign bus_cyc   = cyc_w;
    assign bus_stb   = cyc_w;
    assign loc_done  = (kind != END_NONE);
    assign loc_fault = (kind == END_FAIL);
endmodule

// File: rtl/lwb_bridge_chk.sv
module lwb_bridge_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          loc_wr,
    input logic          loc_rd,
    input logic [AW-1:0] loc_addr,
    input logic [DW-1:0] loc_wdata,
    input logic          loc_done,
    input logic          loc_fault,
    input logic          bus_cyc,
    input logic          bus_stb,
    input logic          bus_we,
    input logic [AW-1:0] bus_adr,
    input logic [DW-1:0] bus_dat_o,
    input logic          bus_ack,
    input logic          bus_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !bus_cyc && !loc_done && !loc_fault);

    assert_double_rejected_R2: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && loc_wr && loc_rd) |=> !bus_cyc);

    assert_start_next_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && (loc_wr ^ loc_rd)) |=> bus_cyc && bus_stb);

    assert_addr_captured_R4: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && (loc_wr ^ loc_rd)) |=> bus_adr == $past(loc_addr) && bus_we == $past(loc_wr));

    assert_wdata_captured_R5: assert property (@(posedge clk) disable iff (rst)
        (!bus_cyc && loc_wr && !loc_rd) |=> bus_dat_o == $past(loc_wdata));

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && !bus_ack && !bus_err) |=> bus_cyc && $stable(bus_adr) && $stable(bus_we) && $stable(bus_dat_o));

    assert_end_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && (bus_ack || bus_err)) |=> !bus_cyc && loc_done);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        loc_done |=> !loc_done);

    assert_fault_with_done_R8: assert property (@(posedge clk) disable iff (rst)
        loc_fault |-> loc_done);

    assert_err_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_cyc && bus_err) |=> loc_fault);
endmodule

bind lwb_bridge lwb_bridge_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_lwb_bridge.sv
module test_lwb_bridge;
    localparam int AW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          loc_wr = 0, loc_rd = 0;
    logic [AW-1:0] loc_addr = '0;
    logic [DW-1:0] loc_wdata = '0;
    logic [DW-1:0] loc_rdata;
    logic          loc_done, loc_fault;
    logic          bus_cyc, bus_stb, bus_we;
    logic [AW-1:0] bus_adr;
    logic [DW-1:0] bus_dat_o;
    logic [DW-1:0] bus_dat_i = '0;
    logic          bus_ack = 0, bus_err = 0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lwb_bridge #(.AW(AW), .DW(DW)) i_lwb_bridge (.*);

    // Behavioural reference: integers and bits, updated at each rising edge
    int m_busy, m_we, m_adr, m_wdat, m_done, m_fault, m_rdata;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_we = 0; m_adr = 0; m_wdat = 0;
            m_done = 0; m_fault = 0; m_rdata = 0;
        end else begin
            m_done = 0; m_fault = 0;
            if (m_busy != 0) begin
                if (bus_ack || bus_err) begin
                    m_busy = 0; m_we = 0; m_done = 1;
                    m_fault = bus_err ? 1 : 0;
                    m_rdata = int'(bus_dat_i);
                end
            end else if (loc_wr != loc_rd) begin
                m_busy = 1; m_we = loc_wr ? 1 : 0;
                m_adr = int'(loc_addr); m_wdat = int'(loc_wdata);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Compares every output with the reference on each falling edge
    always @(negedge clk) begin
        if (!finished) begin
            chk("R1/R2/R3/R9 bus_cyc", int'(bus_cyc), m_busy);
            chk("R3 bus_stb", int'(bus_stb), m_busy);
            chk("R7 loc_done", int'(loc_done), m_done);
            chk("R8/R10 loc_fault", int'(loc_fault), m_fault);
            if (m_busy != 0) begin
                chk("R4 bus_adr", int'(bus_adr), m_adr);
                chk("R4 bus_we", int'(bus_we), m_we);
                if (m_we != 0) chk("R5 bus_dat_o", int'(bus_dat_o), m_wdat);
            end
            if (m_done != 0 && m_fault == 0)
                chk("R7 loc_rdata", int'(loc_rdata), m_rdata);
        end
    end

    task automatic req(input bit w, input bit r, input int a, input int d);
        @(posedge clk); #1;
        loc_wr = w; loc_rd = r; loc_addr = AW'(a); loc_wdata = DW'(d);
        @(posedge clk); #1;
        loc_wr = 0; loc_rd = 0; loc_addr = '0; loc_wdata = '0;
    endtask

    // Slave responds after wait states; drives ack or err for one cycle
    task automatic respond(input int waits, input bit a, input bit e, input int d);
        repeat (waits) @(posedge clk);
        #1; bus_ack = a; bus_err = e; bus_dat_i = DW'(d);
        @(posedge clk); #1;
        bus_ack = 0; bus_err = 0; bus_dat_i = '0;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet under reset
        chk("R1 reset cyc", int'(bus_cyc), 0);
        chk("R1 reset done", int'(loc_done), 0);
        rst = 0;

        // R3 R4 R5: write with 2 wait states
        req(1, 0, 8'h3C, 8'hA5);
        respond(2, 1, 0, 0);
        repeat (2) @(posedge clk);

        // R7: read with data returned
        req(0, 1, 8'hFF, 0);
        respond(0, 1, 0, 8'h5A);
        repeat (2) @(posedge clk);

        // R2: both strobes -> no bus cycle
        req(1, 1, 8'h11, 8'h22);
        repeat (3) @(posedge clk);
        #1 chk("R2 no cycle", int'(bus_cyc), 0);

        // R8: error ends the cycle
        req(0, 1, 8'h00, 0);
        respond(1, 0, 1, 8'h77);
        repeat (2) @(posedge clk);

        // R10: ack and err together
        req(1, 0, 8'h81, 8'h18);
        respond(0, 1, 1, 0);
        repeat (2) @(posedge clk);

        // R9: request during open cycle is ignored
        req(1, 0, 8'h40, 8'h04);
        req(0, 1, 8'h99, 0);
        #1 chk("R9 addr held", int'(bus_adr), 8'h40);
        respond(1, 1, 0, 0);
        repeat (3) @(posedge clk);
        #1 chk("R9 idle after", int'(bus_cyc), 0);

        // R6: slave stalls long, cycle held
        req(0, 1, 8'h7E, 0);
        respond(6, 1, 0, 8'hC3);
        repeat (2) @(posedge clk);

        // R1: reset during an open cycle
        req(1, 0, 8'h12, 8'h34);
        @(posedge clk); #1 rst = 1;
        @(posedge clk); #1;
        chk("R1 reset mid-cycle", int'(bus_cyc), 0);
        rst = 0;
        repeat (3) @(posedge clk);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule